// File: doc/BRIEF.md
# Direct-Mapped FIFO and Mailbox Host Bridge

This block connects a host, which sees an eight-address I/O window, to a board-side agent. Two FIFOs carry bulk traffic: an outbound one (host to board) and an inbound one (board to host). Each FIFO entry holds two byte lanes. A host word access moves both lanes in one entry. A byte access moves only the low lane. When the board runs in narrow (8-bit) mode, each FIFO accepts only half as many entries as in wide mode.

Short messages pass through two 6-bit mailboxes, one in each direction. A status byte reports FIFO and mailbox conditions as levels. A write-only mask register picks which conditions may raise the host interrupt, and one mask bit chooses which mailbox the host reads back. The board side enables the interrupt globally. A write to the reset offset empties both FIFOs, clears both mailboxes and the mask, and sends a one-cycle reset pulse to the board.

Every register is addressed directly. No pointer register is used. Host reads return data combinationally while `h_rd` is high, and any side effect of the read takes place at the next clock edge.

Top module: `hbx_bridge`

## Requirements
- R1: After reset the status byte reads 0x21 (inbound empty, outbound empty), `h_irq` is low, and the mask and readback select are clear.
- R2: A host write at offset 0 pushes one outbound entry. With `h_word` high the entry is `h_wdata[15:0]`. With `h_word` low it is `{8'h00, h_wdata[7:0]}`. The board pops entries in write order on `b_pop_data`, and `b_out_valid` is high while the FIFO is not empty.
- R3: A host read at offset 0 pops one inbound entry. With `h_word` high it returns the whole entry. With `h_word` low it returns `{8'h00, low byte}`, and the high byte of that entry is discarded.
- R4: With `b_wide` high a FIFO is full at 16 entries (FIFO_DEPTH). With `b_wide` low it is full at 8. The half-full flag is set from half of that limit upward. A push into a full FIFO is dropped.
- R5: The status byte at offset 2 is laid out as follows: bit 7 outbound mailbox not yet taken, bit 6 outbound full, bit 5 inbound empty, bit 4 outbound half full, bit 3 inbound half full, bit 2 inbound mailbox full, bit 1 inbound full, bit 0 outbound empty. Every bit follows its condition.
- R6: A mailbox stores only bits [7:2] of the byte written. A host read at offset 3 returns bits [1:0] as zero.
- R7: A board mailbox write sets status bit 2. A host read at offset 3 with readback select clear returns the inbound mailbox and clears bit 2.
- R8: A host write at offset 3 loads the outbound mailbox, presents it on `b_mb_rdata`, and sets status bit 7 until the board pulses `b_mb_rd`. With mask bit 7 set, a read at offset 3 returns the outbound mailbox and clears neither mailbox flag.
- R9: A host write at offset 2 loads the mask. Mask bit 6 enables inbound-mailbox-full, bit 5 inbound full, bit 3 inbound empty, bit 2 outbound full and bit 0 outbound empty. Bits 4 and 1 enable nothing. `h_irq` is high only when `b_irq_en` is high and an enabled condition is true.
- R10: A host write at offset 7 raises `h_board_rst` for exactly the next cycle. At the same edge it empties both FIFOs, clears both mailboxes with their flags, and clears the mask, including readback select.
- R11: A host read at offset 0 while the inbound FIFO is empty returns 0 and changes nothing. A read at offset 1 or 4 to 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host offset within the window |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_word | input | 1 | Word access on the data offset |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, valid while h_rd is high |
| h_irq | output | 1 | Host interrupt request |
| h_board_rst | output | 1 | One-cycle reset pulse to the board |
| b_wide | input | 1 | Board interface runs in 16-bit mode |
| b_push | input | 1 | Board pushes an inbound entry |
| b_push_data | input | 16 | Inbound entry data |
| b_in_full | output | 1 | Inbound FIFO full |
| b_pop | input | 1 | Board pops an outbound entry |
| b_pop_data | output | 16 | Head of the outbound FIFO |
| b_out_valid | output | 1 | Outbound FIFO not empty |
| b_mb_wr | input | 1 | Board writes the inbound mailbox |
| b_mb_wdata | input | 6 | Inbound mailbox data |
| b_mb_rd | input | 1 | Board takes the outbound mailbox |
| b_mb_rdata | output | 6 | Outbound mailbox contents |
| b_irq_en | input | 1 | Global host interrupt enable |

## Verification
Outbound traffic is driven as word writes with complementary and patterned lanes, followed by a byte write whose high lane carries data. A dropped high byte can then be told apart from lanes that are swapped or passed through. Inbound reads alternate word and byte width across successive entries, which shows that a byte read consumes the whole entry and does not leave the high lane queued. Each FIFO is filled to one entry below half, to half and to the limit, in both wide and narrow mode, with one write beyond the limit. This pins down the threshold and the drop-when-full rule separately. The mailbox and interrupt sequences toggle readback select and each mask bit alone, including the two unmapped bits, so that a swapped mapping shows up as a wrong level on `h_irq`.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

   // host window offsets (decoded directly, no pointer register)
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_CTRL = 3'd2;
   localparam logic [2:0] OFS_MBOX = 3'd3;
   localparam logic [2:0] OFS_BRST = 3'd7;

   // status byte bit positions
   localparam int ST_OMB_BUSY  = 7;
   localparam int ST_OUT_FULL  = 6;
   localparam int ST_IN_EMPTY  = 5;
   localparam int ST_OUT_HALF  = 4;
   localparam int ST_IN_HALF   = 3;
   localparam int ST_IMB_FULL  = 2;
   localparam int ST_IN_FULL   = 1;
   localparam int ST_OUT_EMPTY = 0;

   // mask byte bit positions
   localparam int MK_RB_OUT    = 7;
   localparam int MK_IMB       = 6;
   localparam int MK_IN_FULL   = 5;
   localparam int MK_IN_EMPTY  = 3;
   localparam int MK_OUT_FULL  = 2;
   localparam int MK_OUT_EMPTY = 0;

   typedef struct packed {
      logic rb_out;
      logic imb;
      logic in_full;
      logic in_empty;
      logic out_full;
      logic out_empty;
   } hbx_mask_t;

   typedef struct packed {
      logic empty;
      logic full;
      logic half;
   } hbx_fflags_t;

endpackage

// File: rtl/hbx_fifo.sv
module hbx_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     narrow,
   input  logic                     push,
   input  logic [W-1:0]             din,
   input  logic                     pop,
   output logic [W-1:0]             dout,
   output hbx_pkg::hbx_fflags_t     flags,
   output logic [$clog2(DEPTH):0]   level
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] LIM_WIDE   = CW'(DEPTH);
   localparam logic [CW-1:0] LIM_NARROW = CW'(DEPTH / 2);

   generate
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("hbx_fifo: DEPTH must be a power of two of at least 4");
      end
      if (W < 1) begin : g_bad_width
         $error("hbx_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] limit;
   logic          do_push, do_pop;

   assign limit       = narrow ? LIM_NARROW : LIM_WIDE;
   assign flags.empty = (level == '0);
   assign flags.full  = (level >= limit);
   assign flags.half  = (level >= (limit >> 1));
   assign do_push     = push && !flags.full && !flush;
   assign do_pop      = pop && !flags.empty && !flush;
   assign dout        = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         level <= level + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

endmodule

// File: rtl/hbx_mbox.sv
module hbx_mbox #(
   parameter int MB_BITS = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr,
   input  logic [MB_BITS-1:0] wdata,
   input  logic               take,
   output logic [MB_BITS-1:0] value,
   output logic               busy
);
   generate
      if (MB_BITS < 1) begin : g_bad_bits
         $error("hbx_mbox: MB_BITS must be positive");
      end
   endgenerate

   // clear beats write, write beats take
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         busy  <= 1'b0;
      end else if (clr) begin
         value <= '0;
         busy  <= 1'b0;
      end else if (wr) begin
         value <= wdata;
         busy  <= 1'b1;
      end else if (take) begin
         busy  <= 1'b0;
      end
   end

endmodule

// File: rtl/hbx_irq.sv
module hbx_irq #(
   parameter int N_SRC = 5
) (
   input  logic             gate,
   input  logic [N_SRC-1:0] src,
   input  logic [N_SRC-1:0] ena,
   output logic             irq
);
   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("hbx_irq: N_SRC must be positive");
      end
   endgenerate

   logic [N_SRC-1:0] hit;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[i] = src[i] & ena[i];
   end

   assign irq = gate & (|hit);

endmodule

// File: rtl/hbx_bridge.sv
module hbx_bridge
   import hbx_pkg::*;
#(
   parameter int LANE_W     = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int MB_BITS    = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            h_addr,
   input  logic                  h_wr,
   input  logic                  h_rd,
   input  logic                  h_word,
   input  logic [2*LANE_W-1:0]   h_wdata,
   output logic [2*LANE_W-1:0]   h_rdata,
   output logic                  h_irq,
   output logic                  h_board_rst,
   input  logic                  b_wide,
   input  logic                  b_push,
   input  logic [2*LANE_W-1:0]   b_push_data,
   output logic                  b_in_full,
   input  logic                  b_pop,
   output logic [2*LANE_W-1:0]   b_pop_data,
   output logic                  b_out_valid,
   input  logic                  b_mb_wr,
   input  logic [MB_BITS-1:0]    b_mb_wdata,
   input  logic                  b_mb_rd,
   output logic [MB_BITS-1:0]    b_mb_rdata,
   input  logic                  b_irq_en
);
   localparam int WORD_W = 2 * LANE_W;
   localparam int MB_PAD = LANE_W - MB_BITS;
   localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

   generate
      if (LANE_W < 8) begin : g_bad_lane
         $error("hbx_bridge: LANE_W must hold the 8-bit status byte");
      end
      if (MB_BITS > LANE_W) begin : g_bad_mb
         $error("hbx_bridge: mailbox wider than a byte lane");
      end
   endgenerate

   // ---------------- host decode ----------------
   logic hit_data_wr, hit_mask_wr, hit_mb_wr, hit_brst;
   logic hit_data_rd, hit_mb_rd;

   assign hit_data_wr = h_wr && (h_addr == OFS_DATA);
   assign hit_mask_wr = h_wr && (h_addr == OFS_CTRL);
   assign hit_mb_wr   = h_wr && (h_addr == OFS_MBOX);
   assign hit_brst    = h_wr && (h_addr == OFS_BRST);
   assign hit_data_rd = h_rd && (h_addr == OFS_DATA);
   assign hit_mb_rd   = h_rd && (h_addr == OFS_MBOX);

   // ---------------- mask and board reset ----------------
   hbx_mask_t mask_q;
   logic      rb_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q      <= '0;
         h_board_rst <= 1'b0;
      end else begin
         h_board_rst <= hit_brst;
         if (hit_brst) begin
            mask_q <= '0;
         end else if (hit_mask_wr) begin
            mask_q.rb_out    <= h_wdata[MK_RB_OUT];
            mask_q.imb       <= h_wdata[MK_IMB];
            mask_q.in_full   <= h_wdata[MK_IN_FULL];
            mask_q.in_empty  <= h_wdata[MK_IN_EMPTY];
            mask_q.out_full  <= h_wdata[MK_OUT_FULL];
            mask_q.out_empty <= h_wdata[MK_OUT_EMPTY];
         end
      end
   end

   assign rb_sel = mask_q.rb_out;

   // ---------------- FIFOs ----------------
   logic [WORD_W-1:0] out_din, in_head;
   hbx_fflags_t       out_f, in_f;
   logic [LVL_W-1:0]  out_level, in_level;

   assign out_din = h_word ? h_wdata : {{LANE_W{1'b0}}, h_wdata[LANE_W-1:0]};

   hbx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_out_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (hit_brst),
      .narrow(!b_wide),
      .push  (hit_data_wr),
      .din   (out_din),
      .pop   (b_pop),
      .dout  (b_pop_data),
      .flags (out_f),
      .level (out_level)
   );

   hbx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_in_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (hit_brst),
      .narrow(!b_wide),
      .push  (b_push),
      .din   (b_push_data),
      .pop   (hit_data_rd),
      .dout  (in_head),
      .flags (in_f),
      .level (in_level)
   );

   assign b_out_valid = !out_f.empty;
   assign b_in_full   = in_f.full;

   // ---------------- mailboxes ----------------
   logic [MB_BITS-1:0] in_mb_val, out_mb_val, mb_pick;
   logic               in_mb_busy, out_mb_busy;
   logic [LANE_W-1:0]  mb_view;

   hbx_mbox #(.MB_BITS(MB_BITS)) i_in_mbox (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (hit_brst),
      .wr   (b_mb_wr),
      .wdata(b_mb_wdata),
      .take (hit_mb_rd && !rb_sel),
      .value(in_mb_val),
      .busy (in_mb_busy)
   );

   hbx_mbox #(.MB_BITS(MB_BITS)) i_out_mbox (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (hit_brst),
      .wr   (hit_mb_wr),
      .wdata(h_wdata[LANE_W-1 -: MB_BITS]),
      .take (b_mb_rd),
      .value(out_mb_val),
      .busy (out_mb_busy)
   );

   assign b_mb_rdata = out_mb_val;
   assign mb_pick    = rb_sel ? out_mb_val : in_mb_val;

   generate
      if (MB_PAD > 0) begin : g_mb_pad
         assign mb_view = {mb_pick, {MB_PAD{1'b0}}};
      end else begin : g_mb_full
         assign mb_view = mb_pick;
      end
   endgenerate

   // ---------------- status ----------------
   logic [7:0] stat;

   always_comb begin
      stat               = '0;
      stat[ST_OMB_BUSY]  = out_mb_busy;
      stat[ST_OUT_FULL]  = out_f.full;
      stat[ST_IN_EMPTY]  = in_f.empty;
      stat[ST_OUT_HALF]  = out_f.half;
      stat[ST_IN_HALF]   = in_f.half;
      stat[ST_IMB_FULL]  = in_mb_busy;
      stat[ST_IN_FULL]   = in_f.full;
      stat[ST_OUT_EMPTY] = out_f.empty;
   end

   // ---------------- interrupt ----------------
   hbx_irq #(.N_SRC(5)) i_irq (
      .gate(b_irq_en),
      .src ({in_mb_busy, in_f.full, in_f.empty, out_f.full, out_f.empty}),
      .ena ({mask_q.imb, mask_q.in_full, mask_q.in_empty, mask_q.out_full, mask_q.out_empty}),
      .irq (h_irq)
   );

   // ---------------- host read mux ----------------
   always_comb begin
      h_rdata = '0;
      if (h_rd) begin
         case (h_addr)
            OFS_DATA: begin
               if (!in_f.empty)
                  h_rdata = h_word ? in_head : {{LANE_W{1'b0}}, in_head[LANE_W-1:0]};
            end
            OFS_CTRL: h_rdata = {{(WORD_W-8){1'b0}}, stat};
            OFS_MBOX: h_rdata = {{LANE_W{1'b0}}, mb_view};
            default:  h_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/hbx_bridge_chk.sv
module hbx_bridge_chk #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 16,
   parameter int LVL_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        h_addr,
   input logic              h_wr,
   input logic              h_rd,
   input logic [WORD_W-1:0] h_rdata,
   input logic              h_irq,
   input logic              h_board_rst,
   input logic              b_irq_en,
   input logic              b_mb_wr,
   input logic [7:0]        stat,
   input logic              rb_sel,
   input logic [LVL_W-1:0]  out_level,
   input logic [LVL_W-1:0]  in_level
);

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !b_irq_en |-> !h_irq); // R9

   AST_MB_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd && h_addr == 3'd3) |-> (h_rdata[1:0] == 2'b00)); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(out_level) <= DEPTH) && (int'(in_level) <= DEPTH)); // R4

   AST_IN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat[5] && stat[1])); // R5

   AST_IMB_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd && h_addr == 3'd3 && !rb_sel && !b_mb_wr) |=> !stat[2]); // R7

   AST_OMB_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == 3'd3) |=> stat[7]); // R8

   AST_BRST_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == 3'd7) |=> (h_board_rst && stat[5] && stat[0] && !stat[7] && !stat[2])); // R10

endmodule

bind hbx_bridge hbx_bridge_chk #(
   .WORD_W(2 * LANE_W),
   .DEPTH (FIFO_DEPTH),
   .LVL_W ($clog2(FIFO_DEPTH) + 1)
) u_hbx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .h_addr     (h_addr),
   .h_wr       (h_wr),
   .h_rd       (h_rd),
   .h_rdata    (h_rdata),
   .h_irq      (h_irq),
   .h_board_rst(h_board_rst),
   .b_irq_en   (b_irq_en),
   .b_mb_wr    (b_mb_wr),
   .stat       (stat),
   .rb_sel     (rb_sel),
   .out_level  (out_level),
   .in_level   (in_level)
);

// File: tb/test_hbx_bridge.sv
module test_hbx_bridge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  h_addr = '0;
   logic        h_wr = 1'b0, h_rd = 1'b0, h_word = 1'b0;
   logic [15:0] h_wdata = '0;
   logic [15:0] h_rdata;
   logic        h_irq, h_board_rst;
   logic        b_wide = 1'b1, b_push = 1'b0, b_pop = 1'b0;
   logic [15:0] b_push_data = '0;
   logic        b_in_full, b_out_valid;
   logic [15:0] b_pop_data;
   logic        b_mb_wr = 1'b0, b_mb_rd = 1'b0, b_irq_en = 1'b0;
   logic [5:0]  b_mb_wdata = '0;
   logic [5:0]  b_mb_rdata;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          drain = 1'b0;
   bit          done = 1'b0;
   logic [15:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   hbx_bridge i_hbx_bridge (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
      .h_word(h_word), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
      .h_board_rst(h_board_rst), .b_wide(b_wide), .b_push(b_push),
      .b_push_data(b_push_data), .b_in_full(b_in_full), .b_pop(b_pop),
      .b_pop_data(b_pop_data), .b_out_valid(b_out_valid), .b_mb_wr(b_mb_wr),
      .b_mb_wdata(b_mb_wdata), .b_mb_rd(b_mb_rd), .b_mb_rdata(b_mb_rdata),
      .b_irq_en(b_irq_en)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic hwr(input logic [2:0] a, input logic [15:0] d, input bit w);
      @(negedge clk);
      h_addr = a; h_wdata = d; h_word = w; h_wr = 1'b1;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, input bit w, output logic [15:0] d);
      @(negedge clk);
      h_addr = a; h_word = w; h_rd = 1'b1;
      #1 d = h_rdata;
      @(negedge clk);
      h_rd = 1'b0;
   endtask

   task automatic chk_stat(input string req, input logic [7:0] exp);
      logic [15:0] v;
      hrd(3'd2, 1'b0, v);
      check(req, v, {8'h00, exp});
   endtask

   // driver: pushes the expected outbound entry into the scoreboard
   task automatic host_push(input logic [15:0] d, input bit w, input bit accept);
      if (accept) exp_q.push_back(w ? d : {8'h00, d[7:0]});
      hwr(3'd0, d, w);
   endtask

   task automatic bpush(input logic [15:0] d);
      @(negedge clk);
      b_push_data = d; b_push = 1'b1;
      @(negedge clk);
      b_push = 1'b0;
   endtask

   task automatic bmbw(input logic [5:0] d);
      @(negedge clk);
      b_mb_wdata = d; b_mb_wr = 1'b1;
      @(negedge clk);
      b_mb_wr = 1'b0;
   endtask

   task automatic bmbr();
      @(negedge clk);
      b_mb_rd = 1'b1;
      @(negedge clk);
      b_mb_rd = 1'b0;
   endtask

   task automatic wait_drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic irq_is(input string req, input logic exp);
      #1 check(req, {15'h0, h_irq}, {15'h0, exp});
   endtask

   // monitor: pops the outbound FIFO and compares against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         b_pop = 1'b0;
         if (drain && b_out_valid) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R2: got %h expected nothing", b_pop_data);
            end else begin
               check("R2 outbound order/data", b_pop_data, exp_q.pop_front());
            end
            b_pop = 1'b1;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_stat("R1 reset status", 8'h21);
      b_irq_en = 1'b1;
      irq_is("R1 irq after reset", 1'b0);
      b_irq_en = 1'b0;

      // R2 outbound word and byte writes
      drain = 1'b1;
      host_push(16'hA55A, 1'b1, 1'b1);
      host_push(16'h1234, 1'b1, 1'b1);
      host_push(16'hBEEF, 1'b0, 1'b1);
      host_push(16'hFF00, 1'b1, 1'b1);
      host_push(16'h7E81, 1'b0, 1'b1);
      wait_drain();
      chk_stat("R2 outbound drained", 8'h21);

      // R4 wide capacity: limit 16, half at 8
      drain = 1'b0;
      for (int i = 0; i < 17; i++) begin
         host_push(16'h4000 + 16'(i), 1'b1, i < 16);
         if (i == 6)  chk_stat("R4 wide below half", 8'h20);
         if (i == 7)  chk_stat("R4 wide half", 8'h30);
         if (i == 15) chk_stat("R4 wide full", 8'h70);
      end
      chk_stat("R4 wide push dropped when full", 8'h70);
      drain = 1'b1;
      wait_drain();
      chk_stat("R4 wide drained", 8'h21);

      // R4 narrow capacity: limit 8, half at 4
      drain = 1'b0;
      b_wide = 1'b0;
      for (int i = 0; i < 9; i++) begin
         host_push(16'h9100 + 16'(i), 1'b1, i < 8);
         if (i == 2) chk_stat("R4 narrow below half", 8'h20);
         if (i == 3) chk_stat("R4 narrow half", 8'h30);
         if (i == 7) chk_stat("R4 narrow full", 8'h70);
      end
      drain = 1'b1;
      wait_drain();
      chk_stat("R4 narrow drained", 8'h21);
      b_wide = 1'b1;

      // R3 inbound word and byte reads
      bpush(16'h1122);
      bpush(16'h3344);
      bpush(16'h5566);
      chk_stat("R5 inbound not empty", 8'h01);
      hrd(3'd0, 1'b1, v); check("R3 word read", v, 16'h1122);
      hrd(3'd0, 1'b0, v); check("R3 byte read low lane", v, 16'h0044);
      hrd(3'd0, 1'b1, v); check("R3 high byte discarded", v, 16'h5566);
      chk_stat("R5 inbound empty again", 8'h21);
      // R11 empty and unused offsets
      hrd(3'd0, 1'b1, v); check("R11 empty read", v, 16'h0000);
      chk_stat("R11 empty read no effect", 8'h21);
      hrd(3'd5, 1'b0, v); check("R11 unused offset", v, 16'h0000);
      hrd(3'd1, 1'b0, v); check("R11 high data offset read", v, 16'h0000);

      // R6 R7 inbound mailbox
      bmbw(6'h2D);
      chk_stat("R7 inbound mailbox flag", 8'h25);
      hrd(3'd3, 1'b0, v); check("R6 R7 inbound mailbox value", v, 16'h00B4);
      chk_stat("R7 flag cleared by read", 8'h21);

      // R8 outbound mailbox
      hwr(3'd3, 16'h00FF, 1'b0);
      chk_stat("R8 outbound pending", 8'hA1);
      check("R8 board sees mailbox", {10'h0, b_mb_rdata}, 16'h003F);
      hwr(3'd2, 16'h0080, 1'b0);
      hrd(3'd3, 1'b0, v); check("R8 R6 readback outbound", v, 16'h00FC);
      chk_stat("R8 readback keeps pending", 8'hA1);
      bmbw(6'h11);
      hrd(3'd3, 1'b0, v); check("R8 select still outbound", v, 16'h00FC);
      chk_stat("R8 inbound flag kept", 8'hA5);
      bmbr();
      chk_stat("R8 board take clears", 8'h25);
      hwr(3'd2, 16'h0000, 1'b0);
      hrd(3'd3, 1'b0, v); check("R7 inbound after select clear", v, 16'h0044);
      chk_stat("R7 cleared", 8'h21);

      // R9 interrupt mask mapping
      hwr(3'd2, 16'h0001, 1'b0);
      irq_is("R9 gated by enable", 1'b0);
      b_irq_en = 1'b1;
      irq_is("R9 outbound empty enabled", 1'b1);
      hwr(3'd2, 16'h0008, 1'b0);
      irq_is("R9 inbound empty enabled", 1'b1);
      hwr(3'd2, 16'h0004, 1'b0);
      irq_is("R9 outbound full not true", 1'b0);
      hwr(3'd2, 16'h0012, 1'b0);
      irq_is("R9 unmapped bits", 1'b0);
      hwr(3'd2, 16'h0040, 1'b0);
      irq_is("R9 mailbox mask idle", 1'b0);
      bmbw(6'h01);
      irq_is("R9 mailbox irq", 1'b1);
      hrd(3'd3, 1'b0, v);
      irq_is("R9 mailbox irq cleared", 1'b0);
      hwr(3'd2, 16'h0020, 1'b0);
      for (int i = 0; i < 17; i++) bpush(16'hC000 + 16'(i));
      irq_is("R9 inbound full irq", 1'b1);
      check("R4 board full flag", {15'h0, b_in_full}, 16'h0001);
      chk_stat("R4 R5 inbound full", 8'h0B);
      hrd(3'd0, 1'b1, v); check("R4 inbound order", v, 16'hC000);
      chk_stat("R5 inbound below full", 8'h09);

      // R10 reset port
      hwr(3'd2, 16'h0081, 1'b0);
      irq_is("R10 irq before reset", 1'b1);
      hwr(3'd3, 16'h00AC, 1'b0);
      bmbw(6'h15);
      chk_stat("R10 state before reset", 8'h8D);
      hwr(3'd7, 16'h0000, 1'b0);
      #1 check("R10 pulse high", {15'h0, h_board_rst}, 16'h0001);
      @(negedge clk);
      #1 check("R10 pulse one cycle", {15'h0, h_board_rst}, 16'h0000);
      chk_stat("R10 status cleared", 8'h21);
      irq_is("R10 mask cleared", 1'b0);
      hrd(3'd3, 1'b0, v); check("R10 select and mailbox cleared", v, 16'h0000);
      hrd(3'd0, 1'b1, v); check("R10 inbound emptied", v, 16'h0000);
      b_irq_en = 1'b0;

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule